// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a single-clock synchronous static memory of 36-bit words. Every read or write is presented on the command inputs in one cycle, and its data moves exactly two rising edges later. Write data is captured from `din` at that edge. Read data appears on `dout` just after that edge. Because both directions trail their command by the same amount, a host can alternate reads and writes on consecutive cycles without inserting idle bus cycles.

Each word is split into four 9-bit byte lanes, and each lane has its own active-low write enable. A clock-enable input freezes the whole pipeline. Three chip-select inputs gate the start of new operations. An internal two-bit burst counter lets one external address produce four beats in either linear or interleaved order. The data output has a drive-enable flag instead of a real tristate pin: when the flag is low, `dout` stands for high impedance and reads as zero. An asynchronous output-enable input can drop the drive flag at any moment.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded in cycle N (with `cke_n` low in N, N+1 and N+2) drives the stored word on `dout` with `dq_drive` high after the edge that ends cycle N+2. A write loaded in cycle N stores the `din` present at the edge that ends cycle N+2.
- R2: Write and read commands may alternate on consecutive cycles with no idle cycle, and each read returns the data of the most recent earlier write to its address.
- R3: While `cke_n` is high, all other synchronous inputs are ignored and every register holds, including the `dout` and `dq_drive` outputs and the pending pipeline stages. Operations resume, with their remaining latency, once `cke_n` returns low.
- R4: A load cycle (`ld_n` low) starts an operation only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. Failing any one of these gives a deselect cycle, but operations already in the pipeline still complete.
- R5: `dq_drive` is low after the edge that ends the second cycle following a deselect cycle or a write command.
- R6: With `ld_n` high, the burst counter advances. When the burst was loaded with `ilv` low (linear order), beat k (k = 0..3) uses address bits [1:0] equal to (start[1:0] + k) mod 4. The upper address bits stay fixed.
- R7: When the burst was loaded with `ilv` high (interleaved order), beat k uses address bits [1:0] equal to start[1:0] XOR k.
- R8: A burst advance keeps the direction of the load that started the burst. `rd_wr_n` is ignored on advance cycles.
- R9: On a write, lane i (bits 9i+8 down to 9i, i = 0..3) is updated only when `bw_n[i]` is low. The other lanes keep their old contents. `bw_n` is sampled in the same cycle as its command.
- R10: `oe_n` high forces `dq_drive` low immediately, without waiting for a clock edge.
- R11: After reset the pipeline is empty and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| rd_wr_n | input | 1 | High read, low write (used on load cycles) |
| bw_n | input | 4 | Per-lane write enables, active low |
| ilv | input | 1 | Burst order latched at load: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| din | input | 36 | Write data, captured two cycles after its command |
| dout | output | 36 | Read data, zero when not driven |
| dq_drive | output | 1 | High while dout is actively driven |

## Verification
The bench alternates write and read commands back to back, including a read of an address whose write is still in flight. A design that forwarded data out of order or counted latency wrongly would return stale words there. Stalls are inserted while a read sits mid-pipeline, and the stalled cycles carry a write command. A design that let `cke_n` gate only part of the pipeline would shift the read by a cycle, and one that acted on the ignored command would corrupt memory. Both faults show up in a later readback. Bursts start from an unaligned address in both orders, and the read burst flips `rd_wr_n` on its advance cycles. Swapped order formulas, a counter that leaked into the upper address bits, or a direction taken from the live pin would all misplace or overwrite words. Separate checks cover deselect cycles formed by each chip select alone, partial-lane writes and the immediate effect of `oe_n`.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             ld_n,
  input  logic             rd_wr_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             ilv,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_drive
);

  logic [DW-1:0] mem [DEPTH];

  logic          go, sel;
  logic          bst_act, bst_wr, bst_ilv;
  logic [AW-1:0] bst_base;
  logic [1:0]    bst_cnt, nxt_cnt, bst_lo;

  logic             c_v, c_w;
  logic [AW-1:0]    c_a;
  logic             v1, w1, v2, w2, rd_v;
  logic [AW-1:0]    a1, a2;
  logic [LANES-1:0] bw1, bw2;
  logic [DW-1:0]    rdata;

  assign go  = !cke_n;
  assign sel = !ce1_n && ce2 && !ce3_n;

  assign nxt_cnt = bst_cnt + 2'd1;
  assign bst_lo  = bst_ilv ? (bst_base[1:0] ^ nxt_cnt) : (bst_base[1:0] + nxt_cnt);

  assign c_v = ld_n ? bst_act : sel;
  assign c_w = ld_n ? bst_wr  : !rd_wr_n;
  assign c_a = ld_n ? {bst_base[AW-1:2], bst_lo} : addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_act  <= 1'b0;
      bst_wr   <= 1'b0;
      bst_ilv  <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= 2'd0;
      v1 <= 1'b0; w1 <= 1'b0; a1 <= '0; bw1 <= '1;
      v2 <= 1'b0; w2 <= 1'b0; a2 <= '0; bw2 <= '1;
      rd_v <= 1'b0;
    end else if (go) begin
      if (!ld_n) begin
        bst_act  <= sel;
        bst_wr   <= !rd_wr_n;
        bst_ilv  <= ilv;
        bst_base <= addr;
        bst_cnt  <= 2'd0;
      end else if (bst_act) begin
        bst_cnt  <= nxt_cnt;
      end
      v1 <= c_v; w1 <= c_w; a1 <= c_a; bw1 <= bw_n;
      v2 <= v1;  w2 <= w1;  a2 <= a1;  bw2 <= bw1;
      rd_v <= v2 && !w2;
    end
  end

  always_ff @(posedge clk) begin
    if (go && v2) begin
      if (w2) begin
        for (int i = 0; i < LANES; i++)
          if (!bw2[i]) mem[a2][i*LW +: LW] <= din[i*LW +: LW];
      end else begin
        rdata <= mem[a2];
      end
    end
  end

  assign dq_drive = rd_v && !oe_n;
  assign dout     = dq_drive ? rdata : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cke_n,
  input logic ce1_n,
  input logic ce2,
  input logic ce3_n,
  input logic ld_n,
  input logic rd_wr_n,
  input logic oe_n,
  input logic dq_drive,
  input logic rd_v
);
  logic sel_c, rd_ld, nord_ld;
  assign sel_c   = !ce1_n && ce2 && !ce3_n;
  assign rd_ld   = !cke_n && !ld_n && sel_c && rd_wr_n;
  assign nord_ld = !cke_n && !ld_n && (!sel_c || !rd_wr_n);

  assert_oe_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rd_v));

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_ld, 2) && $past(!cke_n) && !cke_n) |=> rd_v);

  assert_idle_after_desel_or_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nord_ld, 2) && $past(!cke_n) && !cke_n) |=> !dq_drive);

  always_comb begin
    if (rst_n && oe_n) assert_oe_now_R10: assert (!dq_drive);
  end
endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
  .ce3_n(ce3_n), .ld_n(ld_n), .rd_wr_n(rd_wr_n), .oe_n(oe_n),
  .dq_drive(dq_drive), .rd_v(rd_v)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic cke_n = 0, ce1_n = 1, ce2 = 0, ce3_n = 1, ld_n = 0, rd_wr_n = 1;
  logic [3:0] bw_n = 4'hF;
  logic ilv = 0, oe_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dq_drive;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zbt_sram #(.DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .ld_n(ld_n), .rd_wr_n(rd_wr_n), .bw_n(bw_n), .ilv(ilv),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dq_drive(dq_drive)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic st(input logic ck, input logic [2:0] ce, input logic ld, input logic rw,
                    input logic [3:0] bw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic il = 0);
    cke_n = ck; ce1_n = ~ce[0]; ce2 = ce[1]; ce3_n = ~ce[2];
    ld_n = ld; rd_wr_n = rw; bw_n = bw; addr = a; din = d; ilv = il;
    @(negedge clk);
  endtask

  task automatic idle(input logic [DW-1:0] d = '0);
    st(0, 3'b000, 0, 1, 4'hF, '0, d);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] bw = 4'h0);
    st(0, 3'b111, 0, 0, bw, a, '0);
    idle();
    idle(d);
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    st(0, 3'b111, 0, 1, 4'hF, a, '0);
    idle();
    idle();
    check({tag, " drive"}, {35'd0, dq_drive}, 36'd1);
    check(tag, dout, exp);
  endtask

  task automatic t_reset;
    check("R11 drive after reset", {35'd0, dq_drive}, 36'd0);
    check("R11 dout after reset", dout, '0);
  endtask

  task automatic t_alternate;
    st(0, 3'b111, 0, 0, 4'h0, 8'h05, '0);
    st(0, 3'b111, 0, 1, 4'hF, 8'h05, '0);
    st(0, 3'b111, 0, 0, 4'h0, 8'h06, 36'hA5A5A5A5A);
    st(0, 3'b111, 0, 1, 4'hF, 8'h06, '0);
    check("R1 R2 read after write drive", {35'd0, dq_drive}, 36'd1);
    check("R1 R2 read after write data", dout, 36'hA5A5A5A5A);
    idle(36'h123456789);
    check("R5 no drive after write", {35'd0, dq_drive}, 36'd0);
    idle();
    check("R2 second read data", dout, 36'h123456789);
    idle();
    idle();
  endtask

  task automatic t_lanes;
    wr(8'h40, 36'hFFFFFFFFF);
    wr(8'h40, 36'h000000000, 4'b1010);
    rd_chk("R9 lanes 0 and 2 written", 8'h40, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
  endtask

  task automatic t_stall;
    wr(8'h50, 36'h0DEADBEEF);
    st(0, 3'b111, 0, 1, 4'hF, 8'h50, '0);
    idle();
    for (int i = 0; i < 3; i++) begin
      st(1, 3'b111, 0, 0, 4'h0, 8'h50, 36'h111111111);
      check("R3 read held during stall", {35'd0, dq_drive}, 36'd0);
    end
    idle();
    check("R3 read after stall drive", {35'd0, dq_drive}, 36'd1);
    check("R3 read after stall data", dout, 36'h0DEADBEEF);
    st(1, 3'b000, 0, 1, 4'hF, '0, '0);
    st(1, 3'b000, 0, 1, 4'hF, '0, '0);
    check("R3 output held in stall", dout, 36'h0DEADBEEF);
    idle();
    idle();
    rd_chk("R3 stalled write ignored", 8'h50, 36'h0DEADBEEF);
  endtask

  task automatic t_deselect;
    wr(8'h60, 36'h0CAFE0123);
    st(0, 3'b111, 0, 1, 4'hF, 8'h60, '0);
    st(0, 3'b110, 0, 1, 4'hF, 8'h61, '0);
    st(0, 3'b101, 0, 0, 4'h0, 8'h60, '0);
    check("R4 in-flight read completes", dout, 36'h0CAFE0123);
    st(0, 3'b011, 0, 0, 4'h0, 8'h60, 36'h222222222);
    check("R5 R4 ce1 deselect", {35'd0, dq_drive}, 36'd0);
    idle(36'h333333333);
    check("R5 R4 ce2 deselect", {35'd0, dq_drive}, 36'd0);
    idle(36'h444444444);
    check("R5 R4 ce3 deselect", {35'd0, dq_drive}, 36'd0);
    rd_chk("R4 deselected writes ignored", 8'h60, 36'h0CAFE0123);
  endtask

  task automatic t_burst_linear;
    st(0, 3'b111, 0, 0, 4'h0, 8'h11, '0, 1'b0);
    st(0, 3'b000, 1, 1, 4'h0, 8'h00, '0, 1'b1);
    st(0, 3'b000, 1, 1, 4'h0, 8'h00, 36'h000000A00);
    st(0, 3'b000, 1, 1, 4'h0, 8'h00, 36'h000000A01);
    idle(36'h000000A02);
    idle(36'h000000A03);
    rd_chk("R6 linear beat0", 8'h11, 36'h000000A00);
    rd_chk("R6 linear beat1", 8'h12, 36'h000000A01);
    rd_chk("R6 linear beat2", 8'h13, 36'h000000A02);
    rd_chk("R6 linear beat3 wraps", 8'h10, 36'h000000A03);
  endtask

  task automatic t_burst_interleaved;
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i), 36'h000000B00 + 36'(i));
    st(0, 3'b111, 0, 1, 4'hF, 8'h31, '0, 1'b1);
    st(0, 3'b000, 1, 0, 4'h0, 8'h00, 36'h999999999, 1'b0);
    st(0, 3'b000, 1, 0, 4'h0, 8'h00, 36'h999999999, 1'b0);
    check("R7 interleaved beat0", dout, 36'h000000B01);
    st(0, 3'b000, 1, 0, 4'h0, 8'h00, 36'h999999999, 1'b0);
    check("R7 interleaved beat1", dout, 36'h000000B00);
    idle(36'h999999999);
    check("R7 interleaved beat2", dout, 36'h000000B03);
    idle(36'h999999999);
    check("R7 interleaved beat3", dout, 36'h000000B02);
    check("R8 burst stays read drive", {35'd0, dq_drive}, 36'd1);
    idle();
    rd_chk("R8 advance did not write", 8'h30, 36'h000000B00);
  endtask

  task automatic t_oe;
    st(0, 3'b111, 0, 1, 4'hF, 8'h05, '0);
    idle();
    idle();
    check("R10 drive before oe", {35'd0, dq_drive}, 36'd1);
    oe_n = 1;
    #1;
    check("R10 oe forces off", {35'd0, dq_drive}, 36'd0);
    oe_n = 0;
    #1;
    check("R10 oe restores", dout, 36'hA5A5A5A5A);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alternate();
    t_lanes();
    t_stall();
    t_deselect();
    t_burst_linear();
    t_burst_interleaved();
    t_oe();
    finish_run();
  end
endmodule